// File: doc/BRIEF.md
# CCD line readout sequencer

This block produces the horizontal drive for one video line leaving the serial shift register of an area image sensor. After a line has been moved from the storage zone into the register, a single strobe starts the sequence. The block first waits through a settling gap with the register clocks parked. It then walks every element of the line, giving each element one full period of two complementary register phases and one short reset pulse on the output node. After the last element it parks the clocks again and holds off any new line for a trailing guard gap.

While it runs, every element is labelled with its class: masked prescan, isolation, shielded dark reference or useful pixel. A sample strobe marks the moment at which the analog front end may digitise the settled output. Downstream clamp logic can therefore pick out black-level and dark pixels without a counter of its own. The line is 1058 elements long when one output carries the whole row, and 546 elements long when each of two outputs carries half of it. In horizontal binning the reset pulse is given on every second element only, so two neighbouring charges add on the output node before they are sampled.

Top module: `ccd_line_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, ph1 is 1, ph2 is 0, charge_rst is 0, pix_class is 0, sample_vld is 0 and line_done is 0.
- R2: ph2 is always the inverse of ph1. Each element lasts EL_CYC = 8 clock cycles. ph1 is low in element cycles 0 to 3 and high in cycles 4 to 7. ph1 stays high outside elements.
- R3: A line_start accepted at a clock edge is followed by LEAD_CYC = 13 cycles with the clocks parked, counting from that edge. Element 0 begins in the cycle after those 13.
- R4: pix_class gives the class of the current element, numbered from 0: elements 0-11 are code 1 (prescan), element 12 is code 2 (isolation), elements 13-28 are code 3 (dark), elements 29-33 are code 2, and every later element is code 4 (useful). Outside elements pix_class is 0.
- R5: The line has 1058 elements when dual_out was 0 at the accepting edge and 546 elements when it was 1.
- R6: Without binning, charge_rst is high in cycles 1 and 2 of every element (16 ns at 125 MHz) and low at all other times.
- R7: With binning (bin_h = 1 at the accepting edge), charge_rst pulses only in elements with an odd index. Even-indexed elements get no reset pulse.
- R8: sample_vld is high for one cycle, in cycle 4 of an element that got a reset pulse, and only if that element is prescan, dark or useful. Isolation elements never raise it.
- R9: line_done is high for exactly one cycle: the cycle right after the last cycle of the last element. In that cycle ph1 is 1 and charge_rst is 0.
- R10: line_start, dual_out and bin_h are ignored from the accepting edge until the block is idle again. A strobe or a mode change during a line does not change that line.
- R11: After line_done, the block stays busy for TAIL_CYC = 13 cycles, and a line_start in that window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Strobe that starts a line when the block is idle |
| dual_out | input | 1 | 1 = half-line per output (546 elements), 0 = full line (1058) |
| bin_h | input | 1 | 1 = horizontal binning of neighbouring pixel pairs |
| ph1 | output | 1 | Register phase 1, parks high |
| ph2 | output | 1 | Register phase 2, complement of ph1 |
| charge_rst | output | 1 | Output-node reset pulse |
| pix_class | output | 3 | Class code of the current element |
| sample_vld | output | 1 | Digitise strobe for prescan, dark and useful samples |
| line_done | output | 1 | One-cycle end-of-line strobe |

## Verification
The bench aims at the map boundaries, namely elements 11/12, 12/13, 28/29, 33/34 and the final element in both line lengths. A wrong comparison there would tag a dark pixel as isolation, drop or add a sample strobe, or end the line one element early or late. Binning is run in both lengths, because a design that picks the wrong parity would reset the even elements and merge the wrong pairs. Strobes and mode changes are sent into the lead gap, the middle of the line and the trailing guard. A design that restarts or relatches there would shift every later compare. The totals of reset pulses and sample strobes per line catch a single lost or extra element even where the timing looks right.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    typedef enum logic [2:0] {
        CLS_NONE    = 3'd0,
        CLS_PRESCAN = 3'd1,
        CLS_ISOL    = 3'd2,
        CLS_DARK    = 3'd3,
        CLS_ACTIVE  = 3'd4
    } pix_cls_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ELEM,
        ST_TAIL
    } seq_st_t;

endpackage

// File: rtl/ccdseq_elem_map.sv
module ccdseq_elem_map
    import ccdseq_pkg::*;
#(
    parameter int PRE_N   = 12,
    parameter int ISO_A_N = 1,
    parameter int DARK_N  = 16,
    parameter int ISO_B_N = 5,
    parameter int IDX_W   = 11
) (
    input  logic [IDX_W-1:0] idx,
    output pix_cls_t         cls
);
    // Region boundaries along the line, in element order
    localparam int END_PRE   = PRE_N;
    localparam int END_ISO_A = END_PRE + ISO_A_N;
    localparam int END_DARK  = END_ISO_A + DARK_N;
    localparam int END_ISO_B = END_DARK + ISO_B_N;

    always_comb begin
        if (int'(idx) < END_PRE)        cls = CLS_PRESCAN;
        else if (int'(idx) < END_ISO_A) cls = CLS_ISOL;
        else if (int'(idx) < END_DARK)  cls = CLS_DARK;
        else if (int'(idx) < END_ISO_B) cls = CLS_ISOL;
        else                            cls = CLS_ACTIVE;
    end

endmodule

// File: rtl/ccdseq_phase_gen.sv
module ccdseq_phase_gen #(
    parameter int EL_CYC    = 8,
    parameter int RST_START = 1,
    parameter int RST_LEN   = 2,
    parameter int SUB_W     = 3
) (
    input  logic [SUB_W-1:0] sub,
    output logic             ph1_low,
    output logic             rst_win,
    output logic             smp_slot
);
    localparam int HALF     = EL_CYC / 2;
    localparam int RST_END  = RST_START + RST_LEN;
    // Sample one cycle after the reset pulse has ended
    localparam int SMP_AT   = RST_END + 1;

    always_comb begin
        ph1_low  = int'(sub) < HALF;
        rst_win  = (int'(sub) >= RST_START) && (int'(sub) < RST_END);
        smp_slot = int'(sub) == SMP_AT;
    end

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
    import ccdseq_pkg::*;
#(
    parameter int PRE_N       = 12,
    parameter int ISO_A_N     = 1,
    parameter int DARK_N      = 16,
    parameter int ISO_B_N     = 5,
    parameter int USEFUL_FULL = 1024,
    parameter int EL_CYC      = 8,
    parameter int RST_START   = 1,
    parameter int RST_LEN     = 2,
    parameter int LEAD_CYC    = 13,
    parameter int TAIL_CYC    = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic       dual_out,
    input  logic       bin_h,
    output logic       ph1,
    output logic       ph2,
    output logic       charge_rst,
    output logic [2:0] pix_class,
    output logic       sample_vld,
    output logic       line_done
);
    localparam int OVERHEAD = PRE_N + ISO_A_N + DARK_N + ISO_B_N;
    localparam int LEN_FULL = OVERHEAD + USEFUL_FULL;
    localparam int LEN_HALF = OVERHEAD + USEFUL_FULL / 2;
    localparam int IDX_W    = $clog2(LEN_FULL);
    localparam int SUB_W    = (EL_CYC > 2) ? $clog2(EL_CYC) : 1;
    localparam int GAP_MAX  = (LEAD_CYC > TAIL_CYC) ? LEAD_CYC : TAIL_CYC;
    localparam int CNT_W    = $clog2(GAP_MAX + 1);

    localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(LEN_FULL - 1);
    localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(LEN_HALF - 1);
    localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(EL_CYC - 1);
    localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYC - 1);

    typedef struct packed {
        seq_st_t          st;
        logic [CNT_W-1:0] cnt;
        logic [SUB_W-1:0] sub;
        logic [IDX_W-1:0] elem;
        logic             dual;
        logic             bin;
        logic             done;
    } seq_t;

    typedef struct packed {
        logic     ph1;
        logic     rst;
        pix_cls_t tag;
        logic     vld;
        logic     done;
    } drv_t;

    seq_t seq_d, seq_q;
    drv_t drv_d, drv_q;

    logic [IDX_W-1:0] last_idx;
    pix_cls_t         nxt_cls;
    logic             nxt_ph1_low;
    logic             nxt_rst_win;
    logic             nxt_smp_slot;

    assign last_idx = seq_q.dual ? LAST_HALF : LAST_FULL;

    // Sequencing: gap counters, element walk, mode latch
    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (line_start) begin
                    seq_d.st   = ST_LEAD;
                    seq_d.cnt  = '0;
                    seq_d.sub  = '0;
                    seq_d.elem = '0;
                    seq_d.dual = dual_out;
                    seq_d.bin  = bin_h;
                end
            end
            ST_LEAD: begin
                if (seq_q.cnt == LEAD_LAST) begin
                    seq_d.st   = ST_ELEM;
                    seq_d.sub  = '0;
                    seq_d.elem = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_ELEM: begin
                if (seq_q.sub == SUB_LAST) begin
                    seq_d.sub = '0;
                    if (seq_q.elem == last_idx) begin
                        seq_d.st   = ST_TAIL;
                        seq_d.cnt  = '0;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.elem = seq_q.elem + 1'b1;
                    end
                end else begin
                    seq_d.sub = seq_q.sub + 1'b1;
                end
            end
            ST_TAIL: begin
                if (seq_q.cnt == TAIL_LAST) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    ccdseq_elem_map #(
        .PRE_N   (PRE_N),
        .ISO_A_N (ISO_A_N),
        .DARK_N  (DARK_N),
        .ISO_B_N (ISO_B_N),
        .IDX_W   (IDX_W)
    ) u_map (
        .idx (seq_d.elem),
        .cls (nxt_cls)
    );

    ccdseq_phase_gen #(
        .EL_CYC    (EL_CYC),
        .RST_START (RST_START),
        .RST_LEN   (RST_LEN),
        .SUB_W     (SUB_W)
    ) u_phase (
        .sub      (seq_d.sub),
        .ph1_low  (nxt_ph1_low),
        .rst_win  (nxt_rst_win),
        .smp_slot (nxt_smp_slot)
    );

    // Output decode from the next sequencing state, so the drive is registered
    logic in_elem_d;
    logic rst_elem_d;
    logic cls_smp_d;

    always_comb begin
        in_elem_d  = seq_d.st == ST_ELEM;
        rst_elem_d = !seq_d.bin || seq_d.elem[0];
        cls_smp_d  = (nxt_cls == CLS_PRESCAN) || (nxt_cls == CLS_DARK) ||
                     (nxt_cls == CLS_ACTIVE);
        drv_d.ph1  = !(in_elem_d && nxt_ph1_low);
        drv_d.rst  = in_elem_d && nxt_rst_win && rst_elem_d;
        drv_d.tag  = in_elem_d ? nxt_cls : CLS_NONE;
        drv_d.vld  = in_elem_d && nxt_smp_slot && rst_elem_d && cls_smp_d;
        drv_d.done = seq_d.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, sub: '0, elem: '0,
                       dual: 1'b0, bin: 1'b0, done: 1'b0};
            drv_q <= '{ph1: 1'b1, rst: 1'b0, tag: CLS_NONE, vld: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
            drv_q <= drv_d;
        end
    end

    assign ph1        = drv_q.ph1;
    assign ph2        = ~drv_q.ph1;
    assign charge_rst = drv_q.rst;
    assign pix_class  = drv_q.tag;
    assign sample_vld = drv_q.vld;
    assign line_done  = drv_q.done;

    // State brought out for the bound checker
    logic             bin_act;
    logic [IDX_W-1:0] elem_idx;
    assign bin_act  = seq_q.bin;
    assign elem_idx = seq_q.elem;

endmodule

// File: rtl/ccdseq_chk.sv
module ccdseq_chk
    import ccdseq_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ph1,
    input logic             ph2,
    input logic             charge_rst,
    input logic [2:0]       pix_class,
    input logic             sample_vld,
    input logic             line_done,
    input logic             bin_act,
    input logic [IDX_W-1:0] elem_idx
);

    // R6: the node reset falls inside the ph1-low half of an element
    assert_rst_in_low_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        charge_rst |-> (!ph1 && ph2));

    // R7: in binning only odd elements get a reset pulse
    assert_bin_odd_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (charge_rst && bin_act) |-> elem_idx[0]);

    // R8: a sample strobe comes one cycle after a reset pulse has ended
    assert_vld_after_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> (!charge_rst && !$past(charge_rst) && $past(charge_rst, 2)));

    // R8: isolation and idle cycles never raise the strobe
    assert_vld_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> (pix_class != 3'(CLS_ISOL) && pix_class != 3'(CLS_NONE)));

    // R9: line_done lasts a single cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    // R9: the clocks are parked when line_done is shown
    assert_done_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (ph1 && !charge_rst && pix_class == 3'(CLS_NONE)));

endmodule

bind ccd_line_seq ccdseq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph1        (ph1),
    .ph2        (ph2),
    .charge_rst (charge_rst),
    .pix_class  (pix_class),
    .sample_vld (sample_vld),
    .line_done  (line_done),
    .bin_act    (bin_act),
    .elem_idx   (elem_idx)
);

// File: tb/tb_ccd_line_seq.sv
`timescale 1ns/1ps
module tb_ccd_line_seq;
    localparam int LEAD  = 13;
    localparam int TAIL  = 13;
    localparam int EL    = 8;
    localparam int LEN_S = 1058;
    localparam int LEN_D = 546;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic dual_out = 1'b0;
    logic bin_h = 1'b0;
    logic ph1, ph2, charge_rst, sample_vld, line_done;
    logic [2:0] pix_class;

    always #4 clk = ~clk;

    ccd_line_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .dual_out   (dual_out),
        .bin_h      (bin_h),
        .ph1        (ph1),
        .ph2        (ph2),
        .charge_rst (charge_rst),
        .pix_class  (pix_class),
        .sample_vld (sample_vld),
        .line_done  (line_done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string ctx = "";
    bit run_cmp = 1'b0;

    // Behavioural model: time since the accepting edge
    int m_act = 0;
    int m_t   = 0;
    int m_len = 0;
    int m_bin = 0;

    function automatic int cls_of(int e);
        if (e < 12) return 1;
        if (e == 12) return 2;
        if (e < 29) return 3;
        if (e < 34) return 2;
        return 4;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s%s %s: actual %0d expected %0d at %0t",
                     req, ctx, what, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 0;
            m_t   = 0;
        end else if (m_act != 0) begin
            m_t++;
            if (m_t == LEAD + m_len * EL + TAIL) m_act = 0;
        end else if (line_start) begin
            m_act = 1;
            m_t   = 0;
            m_len = dual_out ? LEN_D : LEN_S;
            m_bin = bin_h ? 1 : 0;
        end
    end

    // Per-cycle comparison plus per-line tallies
    int rst_tally = 0;
    int vld_tally = 0;
    logic prev_rst = 1'b0;

    always @(negedge clk) begin
        if (run_cmp) begin
            int e, s, cls, e_ph1, e_rst, e_vld, e_done, e_tag, rok;
            bit in_el;
            in_el = (m_act != 0) && (m_t >= LEAD) && (m_t < LEAD + m_len * EL);
            e = in_el ? (m_t - LEAD) / EL : 0;
            s = in_el ? (m_t - LEAD) % EL : 0;
            cls = cls_of(e);
            rok = (m_bin == 0) || (e % 2 == 1);
            e_ph1 = (in_el && s < 4) ? 0 : 1;
            e_rst = (in_el && (s == 1 || s == 2) && rok != 0) ? 1 : 0;
            e_vld = (in_el && s == 4 && rok != 0 && cls != 2) ? 1 : 0;
            e_tag = in_el ? cls : 0;
            e_done = ((m_act != 0) && (m_t == LEAD + m_len * EL)) ? 1 : 0;
            chk((m_act != 0 && m_t < LEAD) ? "R3" : "R2", "ph1", int'(ph1), e_ph1);
            chk("R2", "ph2", int'(ph2), 1 - e_ph1);
            chk(m_bin != 0 ? "R7" : "R6", "charge_rst", int'(charge_rst), e_rst);
            chk("R8", "sample_vld", int'(sample_vld), e_vld);
            chk("R4", "pix_class", int'(pix_class), e_tag);
            chk("R9", "line_done", int'(line_done), e_done);

            if (charge_rst && !prev_rst) rst_tally++;
            if (sample_vld) vld_tally++;
            prev_rst = charge_rst;
            if (line_done) begin
                int exp_r, exp_v;
                exp_r = 0;
                exp_v = 0;
                for (int k = 0; k < m_len; k++) begin
                    if (m_bin == 0 || k % 2 == 1) begin
                        exp_r++;
                        if (cls_of(k) != 2) exp_v++;
                    end
                end
                chk(m_bin != 0 ? "R7" : "R5", "reset pulses per line", rst_tally, exp_r);
                chk("R8", "sample strobes per line", vld_tally, exp_v);
                rst_tally = 0;
                vld_tally = 0;
            end
        end
    end

    task automatic pulse_start(bit d, bit b);
        @(negedge clk);
        dual_out   = d;
        bin_h      = b;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_act != 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R9 watchdog: actual no end expected end of run");
        finish_run();
    end

    initial begin
        // R1: outputs while reset is held
        repeat (3) @(negedge clk);
        chk("R1", "ph1 in reset", int'(ph1), 1);
        chk("R1", "ph2 in reset", int'(ph2), 0);
        chk("R1", "charge_rst in reset", int'(charge_rst), 0);
        chk("R1", "pix_class in reset", int'(pix_class), 0);
        chk("R1", "sample_vld in reset", int'(sample_vld), 0);
        chk("R1", "line_done in reset", int'(line_done), 0);
        rst_n = 1'b1;
        run_cmp = 1'b1;
        repeat (4) @(negedge clk);

        // R5: full line, then half line, no binning
        pulse_start(1'b0, 1'b0);
        wait_idle();
        pulse_start(1'b1, 1'b0);
        wait_idle();

        // R7: binning in both lengths
        pulse_start(1'b1, 1'b1);
        wait_idle();
        pulse_start(1'b0, 1'b1);
        wait_idle();

        // R10: strobes in the lead gap and mid-line, mode inputs flipped
        ctx = " (R10)";
        pulse_start(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (2000) @(negedge clk);
        dual_out = 1'b0;
        bin_h    = 1'b1;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        wait_idle();

        // R11: strobe inside the trailing guard, then a back-to-back line
        ctx = " (R11)";
        pulse_start(1'b1, 1'b1);
        do @(negedge clk); while (!line_done);
        repeat (2) @(negedge clk);
        dual_out = 1'b0;
        bin_h    = 1'b0;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        wait_idle();
        pulse_start(1'b0, 1'b0);
        wait_idle();
        ctx = "";
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule